// File: doc/BRIEF.md
# Local Bus Burst Master Engine

This block runs read and write cycles on a 32-bit synchronous local bus on behalf of an internal buffer manager. A request arrives on a valid/ready stream. It carries an address, four byte enables, write data for up to four beats, a direction bit and a burst flag. The engine then runs the bus cycle. Each transfer opens with an address phase, which is one cycle with the address strobe high. Wait phases follow and repeat until the target signals ready. A burst moves four 32-bit beats, and the address steps by 4 after each beat. Read beats return on a plain strobe with a last-beat flag. That output has no back-pressure, so the consumer must take every beat in the cycle it is offered.

The bus has two ready inputs. Burst ready lets a burst continue without a new address phase. Plain ready ends the beat and forces the next beat to open with a fresh address phase. Plain ready wins when both arrive in the same cycle. A backoff input pushes the engine off the bus mid-cycle, and its drivers are released within one clock. Once backoff clears, the interrupted beat is reissued with a new address phase. Beats that already completed are not repeated. On writes that use only one 16-bit half of the bus, that half is copied onto the other half.

Output floating is modelled by the drive-enable `bus_oe`. While it is low, every master-driven bus output reads zero. Back-pressure on the request stream: a request is taken in a cycle where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only while the engine is idle and backoff is low.

Top module: `lbus_burst_master`

## Requirements
- R1: While reset is held and right after it, `bus_oe`, `bus_ads`, `bus_blast`, `bus_wr`, `bus_dc`, `rd_valid` are low, `bus_addr`/`bus_be`/`bus_dout` are zero, and `req_ready` is high when `bus_boff` is low.
- R2: The cycle after a request is taken is an address phase: `bus_ads`=1, `bus_oe`=1, `bus_addr` = request address with bits 1:0 cleared, `bus_be` = request enables, `bus_wr` = direction (1 = write). Ready inputs are ignored during an address phase, and a wait phase always follows one unless backoff is seen.
- R3: In a wait phase with no ready and no backoff, the next cycle is again a wait phase with unchanged address and byte enables.
- R4: A request with `req_burst`=0 is one beat with `bus_blast`=1 throughout. Either ready ends it, and the engine is idle in the following cycle.
- R5: A burst is 4 beats, at the start address plus 4 times the beat index. `bus_blast` is high only on beat 3. Burst ready alone on a non-final beat moves to the next beat in a wait phase with no address strobe.
- R6: When plain ready is sampled on a non-final beat, whether or not burst ready is also high, the next beat starts with an address phase.
- R7: On a read, `rd_valid` is high in exactly the wait-phase cycles where a ready is sampled and backoff is low, with `rd_data` = `bus_din`. `rd_last` is high only together with the final beat's `rd_valid`.
- R8: When backoff is sampled during an address or wait phase, `bus_oe` is low from the next cycle until the replay. The beat in progress does not complete, even if a ready arrives in the same cycle.
- R9: After backoff clears, the next cycle is an address phase for the same beat that was interrupted. Beats that already completed are not reissued.
- R10: Written data on `bus_dout` is the beat's word. If `bus_be[3:2]` are both 0, bits 31:16 repeat bits 15:0. Otherwise, if `bus_be[1:0]` are both 0, bits 15:0 repeat bits 31:16.
- R11: `req_ready` is high only when no bus cycle is active or suspended and `bus_boff` is low. A request offered under backoff is not taken.
- R12: `bus_dc` is high in every cycle in which `bus_oe` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all timing from rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Start byte address |
| req_be | input | 4 | Byte enables, bit n for byte lane n |
| req_wdata | input | 128 | Write words, beat k in bits 32k+31:32k |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst |
| bus_addr | output | 32 | Bus address, zero when floating |
| bus_be | output | 4 | Bus byte enables |
| bus_dout | output | 32 | Bus write data |
| bus_din | input | 32 | Bus read data |
| bus_oe | output | 1 | Master outputs driven |
| bus_ads | output | 1 | Address phase strobe |
| bus_dc | output | 1 | Data/control qualifier |
| bus_wr | output | 1 | Write cycle indicator |
| bus_blast | output | 1 | Final beat indicator |
| bus_rdy | input | 1 | Plain (non-burst) ready |
| bus_brdy | input | 1 | Burst ready |
| bus_boff | input | 1 | Backoff |
| rd_valid | output | 1 | Read beat strobe |
| rd_data | output | 32 | Read beat data |
| rd_last | output | 1 | Final read beat |

## Verification
Single cycles are run with a varying number of waits and with each ready in turn. This separates the wait handling from the ready decoding. Bursts are run in three patterns: burst ready on every beat, plain ready on some beats, and both readies in the same cycle. Only these patterns show whether a completed beat reopens an address phase or stays in a wait phase. Backoff is raised in the address phase, mid-burst in a wait phase, and in idle with a request waiting. The resulting list of address-phase addresses shows whether the engine replays the interrupted beat and skips finished beats. Half-bus writes on each half separate the two copy directions, and a long random run mixes every input against a cycle-by-cycle model.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_WAIT = 2'd2,
    PH_HELD = 2'd3
  } lbm_phase_e;
endpackage

// File: rtl/lbm_seq.sv
module lbm_seq
  import lbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       boff,
  input  logic       rdy,
  input  logic       brdy,
  input  logic       last_beat,
  output lbm_phase_e phase,
  output logic       beat_done
);
  lbm_phase_e phase_d;

  // a beat completes only in a wait phase, and backoff cancels it
  assign beat_done = (phase == PH_WAIT) && !boff && (rdy || brdy);

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_IDLE: if (take) phase_d = PH_ADDR;
      PH_ADDR: phase_d = boff ? PH_HELD : PH_WAIT;
      PH_WAIT: begin
        if (boff)                 phase_d = PH_HELD;
        else if (beat_done) begin
          if (last_beat)          phase_d = PH_IDLE;
          else if (rdy)           phase_d = PH_ADDR;  // plain ready wins
          else                    phase_d = PH_WAIT;
        end
      end
      PH_HELD: if (!boff) phase_d = PH_ADDR;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/lbm_beat_ctr.sv
module lbm_beat_ctr #(
  parameter int AW    = 32,
  parameter int BEATS = 4,
  parameter int BEW   = 4,
  localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic          burst,
  input  logic [AW-1:0] base,
  output logic [BW-1:0] beat,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BEW - 1);
  localparam int            SHIFT      = $clog2(BEW);

  assign last = !burst || (beat == BW'(BEATS - 1));
  assign addr = (base & ALIGN_MASK) + (AW'(beat) << SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat <= '0;
    else if (clear)   beat <= '0;
    else if (advance) beat <= beat + BW'(1);
  end
endmodule

// File: rtl/lbm_lane_dup.sv
module lbm_lane_dup #(
  parameter int DW   = 32,
  localparam int BEW = DW / 8,
  localparam int HB  = BEW / 2,
  localparam int HW  = DW / 2
) (
  input  logic [BEW-1:0] be,
  input  logic [DW-1:0]  word,
  output logic [DW-1:0]  lanes
);
  always_comb begin
    if (be[BEW-1:HB] == '0)      lanes = {word[HW-1:0], word[HW-1:0]};
    else if (be[HB-1:0] == '0)   lanes = {word[DW-1:HW], word[DW-1:HW]};
    else                         lanes = word;
  end
endmodule

// File: rtl/lbus_burst_master.sv
module lbus_burst_master
  import lbm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW/8-1:0]     req_be,
  input  logic [DW*BEATS-1:0] req_wdata,
  input  logic                req_write,
  input  logic                req_burst,
  output logic [AW-1:0]       bus_addr,
  output logic [DW/8-1:0]     bus_be,
  output logic [DW-1:0]       bus_dout,
  input  logic [DW-1:0]       bus_din,
  output logic                bus_oe,
  output logic                bus_ads,
  output logic                bus_dc,
  output logic                bus_wr,
  output logic                bus_blast,
  input  logic                bus_rdy,
  input  logic                bus_brdy,
  input  logic                bus_boff,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic                rd_last
);
  localparam int BEW = DW / 8;
  localparam int BW  = (BEATS > 1) ? $clog2(BEATS) : 1;

  lbm_phase_e          phase;
  logic                take, beat_done, last_beat;
  logic [AW-1:0]       addr_q, beat_addr;
  logic [BEW-1:0]      be_q;
  logic [DW*BEATS-1:0] wdata_q;
  logic                write_q, burst_q;
  logic [BW-1:0]       beat;
  logic [DW-1:0]       beat_word, lanes;
  logic                drive;

  assign req_ready = (phase == PH_IDLE) && !bus_boff;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      burst_q <= 1'b0;
    end else if (take) begin
      addr_q  <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
      write_q <= req_write;
      burst_q <= req_burst;
    end
  end

  lbm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .boff      (bus_boff),
    .rdy       (bus_rdy),
    .brdy      (bus_brdy),
    .last_beat (last_beat),
    .phase     (phase),
    .beat_done (beat_done)
  );

  lbm_beat_ctr #(.AW(AW), .BEATS(BEATS), .BEW(BEW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (take),
    .advance (beat_done && !last_beat),
    .burst   (burst_q),
    .base    (addr_q),
    .beat    (beat),
    .addr    (beat_addr),
    .last    (last_beat)
  );

  always_comb begin
    beat_word = '0;
    for (int i = 0; i < BEATS; i++)
      if (beat == BW'(i)) beat_word = wdata_q[i*DW +: DW];
  end

  lbm_lane_dup #(.DW(DW)) u_dup (
    .be    (be_q),
    .word  (beat_word),
    .lanes (lanes)
  );

  assign drive = (phase == PH_ADDR) || (phase == PH_WAIT);

  always_comb begin
    bus_oe    = drive;
    bus_dc    = drive;
    bus_ads   = (phase == PH_ADDR);
    bus_addr  = drive ? beat_addr : '0;
    bus_be    = drive ? be_q : '0;
    bus_wr    = drive && write_q;
    bus_blast = drive && last_beat;
    bus_dout  = (drive && write_q) ? lanes : '0;
  end

  assign rd_valid = beat_done && !write_q;
  assign rd_data  = bus_din;
  assign rd_last  = rd_valid && last_beat;
endmodule

// File: rtl/lbm_chk.sv
module lbm_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic [AW-1:0]   bus_addr,
  input logic [DW/8-1:0] bus_be,
  input logic [DW-1:0]   bus_dout,
  input logic            bus_oe,
  input logic            bus_ads,
  input logic            bus_dc,
  input logic            bus_wr,
  input logic            bus_blast,
  input logic            bus_rdy,
  input logic            bus_brdy,
  input logic            bus_boff,
  input logic            rd_valid,
  input logic            rd_last
);
  localparam int HW = DW / 2;
  localparam int HB = DW / 16;

  // R2
  addr_phase_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ads && !bus_boff) |=> (bus_oe && !bus_ads && $stable(bus_addr)));

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !bus_ads && !bus_rdy && !bus_brdy && !bus_boff)
      |=> (bus_oe && !bus_ads && $stable(bus_addr) && $stable(bus_be)));

  // R4
  last_beat_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !bus_ads && bus_blast && (bus_rdy || bus_brdy) && !bus_boff) |=> !bus_oe);

  // R5
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !bus_ads && !bus_blast && bus_brdy && !bus_rdy && !bus_boff)
      |=> (bus_oe && !bus_ads && (bus_addr == $past(bus_addr) + AW'(4))));

  // R6
  plain_ready_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !bus_ads && !bus_blast && bus_rdy && !bus_boff) |=> bus_ads);

  // R7
  rd_last_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> (rd_valid && bus_blast));

  // R8
  backoff_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_boff && bus_oe) |=> !bus_oe);

  // R10
  lane_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && bus_wr && (bus_be[DW/8-1:HB] == '0)) |-> (bus_dout[DW-1:HW] == bus_dout[HW-1:0]));

  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_oe && !bus_boff));

  // R12
  dc_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_dc && (bus_addr[1:0] == 2'b00)));
endmodule

bind lbus_burst_master lbm_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_dout  (bus_dout),
  .bus_oe    (bus_oe),
  .bus_ads   (bus_ads),
  .bus_dc    (bus_dc),
  .bus_wr    (bus_wr),
  .bus_blast (bus_blast),
  .bus_rdy   (bus_rdy),
  .bus_brdy  (bus_brdy),
  .bus_boff  (bus_boff),
  .rd_valid  (rd_valid),
  .rd_last   (rd_last)
);

// File: tb/test_lbus_burst_master.sv
module test_lbus_burst_master;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic [3:0]   req_be = '0;
  logic [127:0] req_wdata = '0;
  logic         req_write = 1'b0;
  logic         req_burst = 1'b0;
  logic [31:0]  bus_addr;
  logic [3:0]   bus_be;
  logic [31:0]  bus_dout;
  logic [31:0]  bus_din = '0;
  logic         bus_oe, bus_ads, bus_dc, bus_wr, bus_blast;
  logic         bus_rdy = 1'b0;
  logic         bus_brdy = 1'b0;
  logic         bus_boff = 1'b0;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic         rd_last;

  lbus_burst_master i_lbus_burst_master (.*);

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 address phase, 2 wait phase, 3 held off
  int           m_phase = 0;
  int           m_beat = 0;
  bit           m_took = 0;
  logic [31:0]  m_addr = '0;
  logic [3:0]   m_be = '0;
  logic [127:0] m_wdata = '0;
  bit           m_wr = 0, m_burst = 0;

  function automatic bit m_last();
    return !m_burst || (m_beat == 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_beat = 0; m_took = 0;
    end else begin
      m_took = 0;
      case (m_phase)
        0: if (req_valid && !bus_boff) begin
             m_addr = req_addr; m_be = req_be; m_wdata = req_wdata;
             m_wr = req_write; m_burst = req_burst; m_beat = 0;
             m_phase = 1; m_took = 1;
           end
        1: m_phase = bus_boff ? 3 : 2;
        2: if (bus_boff) m_phase = 3;
           else if (bus_rdy || bus_brdy) begin
             if (m_last()) m_phase = 0;
             else begin
               m_beat++;
               m_phase = bus_rdy ? 1 : 2;
             end
           end
        default: if (!bus_boff) m_phase = 1;
      endcase
    end
  end

  logic [31:0] ads_log[$];
  int          rdv_cnt = 0, rdl_cnt = 0;
  logic [31:0] last_dout = '0;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit          drv, e_rdv;
      logic [31:0] e_addr, word, e_dout;
      drv    = (m_phase == 1) || (m_phase == 2);
      e_addr = drv ? ((m_addr & ~32'h3) + 32'(4 * m_beat)) : 32'h0;
      word   = m_wdata[m_beat*32 +: 32];
      if (m_be[3:2] == 2'b00)      word = {word[15:0], word[15:0]};
      else if (m_be[1:0] == 2'b00) word = {word[31:16], word[31:16]};
      e_dout = (drv && m_wr) ? word : 32'h0;
      e_rdv  = (m_phase == 2) && !bus_boff && (bus_rdy || bus_brdy) && !m_wr;
      chk(req_ready == ((m_phase == 0) && !bus_boff), "R11 req_ready", 32'(req_ready), 32'((m_phase == 0) && !bus_boff));
      chk(bus_oe == drv, "R8 bus_oe", 32'(bus_oe), 32'(drv));
      chk(bus_dc == drv, "R12 bus_dc", 32'(bus_dc), 32'(drv));
      chk(bus_ads == (m_phase == 1), "R2/R6/R9 bus_ads", 32'(bus_ads), 32'(m_phase == 1));
      chk(bus_addr == e_addr, "R3/R5 bus_addr", bus_addr, e_addr);
      chk(bus_be == (drv ? m_be : 4'h0), "R2 bus_be", 32'(bus_be), 32'(drv ? m_be : 4'h0));
      chk(bus_wr == (drv && m_wr), "R2 bus_wr", 32'(bus_wr), 32'(drv && m_wr));
      chk(bus_blast == (drv && m_last()), "R4 bus_blast", 32'(bus_blast), 32'(drv && m_last()));
      chk(bus_dout == e_dout, "R10 bus_dout", bus_dout, e_dout);
      chk(rd_valid == e_rdv, "R7 rd_valid", 32'(rd_valid), 32'(e_rdv));
      chk(rd_last == (e_rdv && m_last()), "R7 rd_last", 32'(rd_last), 32'(e_rdv && m_last()));
      if (e_rdv) chk(rd_data == bus_din, "R7 rd_data", rd_data, bus_din);
      if (bus_ads) ads_log.push_back(bus_addr);
      if (rd_valid) rdv_cnt++;
      if (rd_last) rdl_cnt++;
      if (bus_oe && bus_wr) last_dout = bus_dout;
    end
  end

  task automatic step(input logic r, input logic b, input logic o);
    @(negedge clk);
    bus_rdy = r; bus_brdy = b; bus_boff = o;
    bus_din = $urandom;
  endtask

  task automatic issue(input logic [31:0] a, input logic [3:0] be, input logic wr,
                       input logic bu, input logic [127:0] wd);
    @(negedge clk);
    req_addr = a; req_be = be; req_write = wr; req_burst = bu; req_wdata = wd;
    req_valid = 1'b1; bus_rdy = 1'b0; bus_brdy = 1'b0; bus_boff = 1'b0;
    do @(negedge clk); while (!m_took);
    req_valid = 1'b0;
  endtask

  task automatic clear_logs();
    ads_log.delete(); rdv_cnt = 0; rdl_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: state under reset
    chk(!bus_oe && !bus_ads && !bus_blast && !bus_wr && !bus_dc && !rd_valid, "R1 outputs low", 32'({bus_oe, bus_ads, bus_blast, bus_wr, bus_dc, rd_valid}), 32'h0);
    chk(bus_addr == 0 && bus_be == 0 && bus_dout == 0, "R1 bus fields zero", bus_addr, 32'h0);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);
    @(negedge clk); rst_n = 1'b1;

    // R4/R7: single read, two waits, plain ready
    clear_logs();
    issue(32'h0000_0013, 4'hF, 1'b0, 1'b0, '0);
    step(0,0,0); step(0,0,0); step(1,0,0); step(0,0,0);
    chk(rdv_cnt == 1 && rdl_cnt == 1, "R4 single read beats", 32'(rdv_cnt), 32'h1);
    chk(ads_log.size() == 1 && ads_log[0] == 32'h10, "R2 single read address", ads_log.size() > 0 ? ads_log[0] : 32'hX, 32'h10);

    // R10: low-half write, burst ready used as single ready (R4)
    issue(32'h0000_0020, 4'b0011, 1'b1, 1'b0, {96'h0, 32'h1234_BEEF});
    step(0,1,0); step(0,0,0);
    chk(last_dout == 32'hBEEF_BEEF, "R10 low half copied up", last_dout, 32'hBEEF_BEEF);

    // R10: high-byte write
    issue(32'h0000_0024, 4'b1000, 1'b1, 1'b0, {96'h0, 32'hA511_7788});
    step(1,0,0); step(0,0,0);
    chk(last_dout == 32'hA511_A511, "R10 high half copied down", last_dout, 32'hA511_A511);

    // R5/R7: burst read, burst ready every beat
    clear_logs();
    issue(32'h0000_0300, 4'hF, 1'b0, 1'b1, '0);
    step(0,1,0); step(0,1,0); step(0,1,0); step(0,1,0); step(0,0,0);
    chk(rdv_cnt == 4, "R5 burst beat count", 32'(rdv_cnt), 32'h4);
    chk(rdl_cnt == 1, "R7 one last flag", 32'(rdl_cnt), 32'h1);
    chk(ads_log.size() == 1, "R5 single address phase", 32'(ads_log.size()), 32'h1);

    // R6: burst write, plain ready on beat 1, both readies on beat 2
    clear_logs();
    issue(32'h0000_0200, 4'hF, 1'b1, 1'b1, {32'hD3, 32'hC2, 32'hB1, 32'hA0});
    step(0,1,0); step(1,0,0); step(0,0,0); step(1,1,0); step(0,0,0); step(0,1,0); step(0,0,0);
    chk(ads_log.size() == 3, "R6 address phase count", 32'(ads_log.size()), 32'h3);
    if (ads_log.size() == 3) begin
      chk(ads_log[1] == 32'h208, "R6 reopen after plain ready", ads_log[1], 32'h208);
      chk(ads_log[2] == 32'h20C, "R6 plain ready beats burst ready", ads_log[2], 32'h20C);
    end

    // R8/R9: backoff mid-burst in a wait phase, with burst ready in the same cycle
    clear_logs();
    issue(32'h0000_0100, 4'hF, 1'b0, 1'b1, '0);
    step(0,1,0); step(0,1,0); step(0,1,1); step(0,0,1); step(0,0,0); step(0,0,0);
    step(0,1,0); step(0,1,0); step(0,0,0);
    chk(rdv_cnt == 4, "R9 no beat repeated or lost", 32'(rdv_cnt), 32'h4);
    chk(ads_log.size() == 2 && ads_log[1] == 32'h108, "R9 replay address", ads_log.size() > 1 ? ads_log[1] : 32'hX, 32'h108);

    // R8/R9: backoff in the address phase
    clear_logs();
    issue(32'h0000_0400, 4'hF, 1'b0, 1'b0, '0);
    bus_boff = 1'b1;
    step(0,0,1);
    #1 chk(bus_oe == 1'b0, "R8 floated while held", 32'(bus_oe), 32'h0);
    step(0,0,0); step(0,0,0); step(1,0,0); step(0,0,0);
    chk(ads_log.size() == 2 && ads_log[1] == 32'h400, "R9 replay single", ads_log.size() > 1 ? ads_log[1] : 32'hX, 32'h400);

    // R11: request under backoff is not taken
    @(negedge clk);
    req_addr = 32'h500; req_burst = 1'b0; req_write = 1'b0; req_valid = 1'b1; bus_boff = 1'b1;
    #1 chk(req_ready == 1'b0, "R11 no accept under backoff", 32'(req_ready), 32'h0);
    @(negedge clk); #1;
    chk(bus_oe == 1'b0, "R11 stays idle under backoff", 32'(bus_oe), 32'h0);
    @(negedge clk); req_valid = 1'b0; bus_boff = 1'b0;

    // mixed random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (m_took || !req_valid) begin
        req_valid = ($urandom % 10) < 6;
        req_addr  = $urandom;
        req_be    = 4'($urandom);
        req_write = 1'($urandom);
        req_burst = 1'($urandom);
        req_wdata = {$urandom, $urandom, $urandom, $urandom};
      end
      bus_rdy  = ($urandom % 4) == 0;
      bus_brdy = ($urandom % 5) < 2;
      bus_boff = ($urandom % 10) == 0;
      bus_din  = $urandom;
    end
    @(negedge clk);
    req_valid = 1'b0; bus_rdy = 1'b0; bus_brdy = 1'b0; bus_boff = 1'b0;
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule